// File: doc/BRIEF.md
# SPI Chip-Select Sequencer

This block generates the target-select lines of an SPI master. A 10-bit configuration word holds three fields. The low eight bits are a target mask. The next bit chooses who owns the lines. The top bit flips the electrical polarity of every line. All three fields are written through a single write strobe.

The block has two ownership modes:

- **Hardware mode.** A small sequencer decides when the masked lines are asserted. It follows the shifter's transfer-active flag, the transmit-queue-empty flag and an SCK-period tick. An optional hold input keeps the select asserted for a whole message, even across gaps where the transmit queue runs dry.
- **Direct mode.** The mask bits drive the lines by themselves, and the sequencer is ignored.

Every select output is taken from a flop, so a change to the configuration can never produce a glitch. A status bit reports whether any line is currently asserted. The block has an asynchronous active-low reset input. The block releases that reset synchronously to the clock.

Top module: `ssel_ctrl`

## Requirements
- R1: After reset, every select line is high (deasserted, polarity not inverted) and `sel_active` is 0.
- R2: With configuration bit 8 set (direct mode), line i is asserted exactly when mask bit i (bits 7:0) is set. The output shows this on the second clock edge after the write. `xfer_active`, `txq_empty`, `hold_sel` and `sck_tick` have no effect in this mode.
- R3: In hardware mode (bit 8 clear), while the sequencer is idle, all lines are deasserted whatever the mask holds. This includes the moment after leaving direct mode.
- R4: In hardware mode, when `xfer_active` rises from idle, exactly the masked lines assert on the second clock edge. Unmasked lines stay deasserted.
- R5: Without hold, once `xfer_active` is low and `txq_empty` is high, the select stays asserted until the first `sck_tick` pulse. It deasserts at the outputs one clock after that tick is sampled.
- R6: In hardware mode, a gap in `xfer_active` while `txq_empty` is low keeps the select asserted.
- R7: While `hold_sel` is high, an asserted hardware select stays asserted, regardless of `xfer_active`, `txq_empty` and ticks. After `hold_sel` drops, the release follows R5.
- R8: With configuration bit 9 set, an asserted line drives 1 and a deasserted line drives 0. With bit 9 clear, an asserted line drives 0 and a deasserted line drives 1.
- R9: `sel_active` is 1 exactly when at least one line is asserted, with the same timing as the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 10 | Configuration word: [7:0] mask, [8] direct, [9] invert |
| xfer_active | input | 1 | Shifter is moving a frame |
| txq_empty | input | 1 | Transmit queue holds no frame |
| hold_sel | input | 1 | Keep select asserted across queue-empty gaps |
| sck_tick | input | 1 | One-cycle pulse once per SCK period |
| ssel_o | output | 8 | Select lines |
| sel_active | output | 1 | Some select line is asserted |

## Verification
The checker assumes the following about the inputs:

- `sck_tick` is a single-cycle pulse.
- The shifter flags are synchronous to `clk`.
- Configuration writes may arrive at any time.

The sequencer checks rely on this last point. They reason only about the previous cycle's configuration and sequencer state, never about when the writes happen. The directed stimulus drives every input on the falling edge. It pulses the tick for exactly one cycle, and it returns the sequencer to idle at the end of each scenario, so every scenario starts from a known state.

// File: rtl/ssel_pkg.sv
package ssel_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_TAIL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ssel_rst_sync.sv
module ssel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ssel_cfg_reg.sv
module ssel_cfg_reg #(
  parameter int NUM_SEL = 8,
  localparam int CFG_W = NUM_SEL + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CFG_W-1:0]   wdata,
  output logic [NUM_SEL-1:0] mask_q,
  output logic               direct_q,
  output logic               inv_q
);
  localparam int DIRECT_POS = NUM_SEL;
  localparam int INV_POS    = NUM_SEL + 1;

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= wdata;
  end

  assign mask_q   = cfg_q[NUM_SEL-1:0];
  assign direct_q = cfg_q[DIRECT_POS];
  assign inv_q    = cfg_q[INV_POS];
endmodule

// File: rtl/ssel_hw_seq.sv
module ssel_hw_seq
  import ssel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_active,
  input  logic txq_empty,
  input  logic hold_sel,
  input  logic sck_tick,
  output logic hw_on
);
  seq_state_e state_q, state_d;
  logic       keep;

  assign keep = xfer_active || !txq_empty || hold_sel;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (xfer_active) state_d = SEQ_RUN;
      SEQ_RUN:  if (!keep)       state_d = SEQ_TAIL;
      SEQ_TAIL: begin
        if (keep)          state_d = SEQ_RUN;
        else if (sck_tick) state_d = SEQ_IDLE;
      end
      default:             state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign hw_on = (state_q != SEQ_IDLE);
endmodule

// File: rtl/ssel_out_stage.sv
module ssel_out_stage #(
  parameter int NUM_SEL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SEL-1:0] mask,
  input  logic               direct,
  input  logic               inv,
  input  logic               hw_on,
  output logic [NUM_SEL-1:0] lines_q,
  output logic               active_q
);
  logic [NUM_SEL-1:0] assert_d;
  logic [NUM_SEL-1:0] lines_d;
  logic               own;

  assign own = direct || hw_on;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
    assign assert_d[i] = mask[i] && own;
    assign lines_d[i]  = inv ? assert_d[i] : !assert_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q  <= '1;
      active_q <= 1'b0;
    end else begin
      lines_q  <= lines_d;
      active_q <= |assert_d;
    end
  end
endmodule

// File: rtl/ssel_ctrl.sv
module ssel_ctrl #(
  parameter int NUM_SEL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [NUM_SEL+1:0] cfg_wdata,
  input  logic               xfer_active,
  input  logic               txq_empty,
  input  logic               hold_sel,
  input  logic               sck_tick,
  output logic [NUM_SEL-1:0] ssel_o,
  output logic               sel_active
);
  logic               rst_sync_n;
  logic [NUM_SEL-1:0] mask_q;
  logic               direct_q;
  logic               inv_q;
  logic               hw_on;

  ssel_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ssel_cfg_reg #(.NUM_SEL(NUM_SEL)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .mask_q   (mask_q),
    .direct_q (direct_q),
    .inv_q    (inv_q)
  );

  ssel_hw_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .xfer_active (xfer_active),
    .txq_empty   (txq_empty),
    .hold_sel    (hold_sel),
    .sck_tick    (sck_tick),
    .hw_on       (hw_on)
  );

  ssel_out_stage #(.NUM_SEL(NUM_SEL)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mask     (mask_q),
    .direct   (direct_q),
    .inv      (inv_q),
    .hw_on    (hw_on),
    .lines_q  (ssel_o),
    .active_q (sel_active)
  );
endmodule

// File: rtl/ssel_ctrl_chk.sv
module ssel_ctrl_chk #(
  parameter int NUM_SEL = 8
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [NUM_SEL-1:0] mask_q,
  input logic               direct_q,
  input logic               inv_q,
  input logic               hw_on,
  input logic               hold_sel,
  input logic               sck_tick,
  input logic [NUM_SEL-1:0] ssel_o,
  input logic               sel_active
);
  // R2
  direct_follows_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(direct_q) |-> (sel_active == ($past(mask_q) != '0)));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!$past(direct_q) && !$past(hw_on)) |-> !sel_active);

  // R5
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(hw_on) |-> $past(sck_tick));

  // R7
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(hw_on) && $past(hold_sel)) |-> hw_on);

  // R9
  status_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_active == ((($past(inv_q)) ? ssel_o : ~ssel_o) != '0));
endmodule

bind ssel_ctrl ssel_ctrl_chk #(.NUM_SEL(NUM_SEL)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .mask_q     (mask_q),
  .direct_q   (direct_q),
  .inv_q      (inv_q),
  .hw_on      (hw_on),
  .hold_sel   (hold_sel),
  .sck_tick   (sck_tick),
  .ssel_o     (ssel_o),
  .sel_active (sel_active)
);

// File: tb/test_ssel_ctrl.sv
module test_ssel_ctrl;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [9:0] cfg_wdata;
  logic       xfer_active;
  logic       txq_empty;
  logic       hold_sel;
  logic       sck_tick;
  logic [7:0] ssel_o;
  logic       sel_active;

  int n_vec;
  int n_bad;
  bit done;

  ssel_ctrl #(.NUM_SEL(8)) i_ssel_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .xfer_active (xfer_active),
    .txq_empty   (txq_empty),
    .hold_sel    (hold_sel),
    .sck_tick    (sck_tick),
    .ssel_o      (ssel_o),
    .sel_active  (sel_active)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] exp_l, input logic exp_a);
    n_vec++;
    if (ssel_o !== exp_l || sel_active !== exp_a) begin
      n_bad++;
      $display("FAIL %s: lines=%h active=%b expected lines=%h active=%b",
               tag, ssel_o, sel_active, exp_l, exp_a);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic inv, input logic direct, input logic [7:0] mask);
    cfg_we    = 1'b1;
    cfg_wdata = {inv, direct, mask};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic pulse_tick();
    sck_tick = 1'b1;
    @(negedge clk);
    sck_tick = 1'b0;
  endtask

  task automatic back_to_idle();
    xfer_active = 1'b0;
    txq_empty   = 1'b1;
    hold_sel    = 1'b0;
    wait_n(2);
    pulse_tick();
    wait_n(2);
  endtask

  task automatic t_reset();
    check("R1 reset lines", 8'hFF, 1'b0);
  endtask

  task automatic t_hw_idle();
    write_cfg(1'b0, 1'b0, 8'h05);
    wait_n(3);
    check("R3 hw idle masked", 8'hFF, 1'b0);
  endtask

  task automatic t_hw_start_gap_tail();
    xfer_active = 1'b1;
    txq_empty   = 1'b0;
    wait_n(1);
    check("R4 not yet asserted", 8'hFF, 1'b0);
    wait_n(1);
    check("R4 masked asserted", 8'hFA, 1'b1);
    xfer_active = 1'b0;
    wait_n(4);
    check("R6 gap with queued data", 8'hFA, 1'b1);
    txq_empty = 1'b1;
    wait_n(4);
    check("R5 held until tick", 8'hFA, 1'b1);
    pulse_tick();
    check("R5 tick sampled", 8'hFA, 1'b1);
    wait_n(1);
    check("R5 released", 8'hFF, 1'b0);
  endtask

  task automatic t_hold();
    hold_sel    = 1'b1;
    xfer_active = 1'b1;
    txq_empty   = 1'b0;
    wait_n(2);
    check("R7 asserted", 8'hFA, 1'b1);
    xfer_active = 1'b0;
    txq_empty   = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_n(1);
      pulse_tick();
    end
    wait_n(1);
    check("R7 held across ticks", 8'hFA, 1'b1);
    hold_sel = 1'b0;
    wait_n(2);
    check("R7 hold dropped, awaiting tick", 8'hFA, 1'b1);
    pulse_tick();
    wait_n(1);
    check("R7 released after tick", 8'hFF, 1'b0);
  endtask

  task automatic t_direct();
    write_cfg(1'b0, 1'b1, 8'h81);
    wait_n(1);
    check("R2 direct mask", 8'h7E, 1'b1);
    xfer_active = 1'b1;
    txq_empty   = 1'b0;
    wait_n(3);
    check("R2 shifter ignored", 8'h7E, 1'b1);
    back_to_idle();
    check("R2 tick ignored", 8'h7E, 1'b1);
    write_cfg(1'b0, 1'b1, 8'h00);
    wait_n(1);
    check("R9 direct empty mask", 8'hFF, 1'b0);
    write_cfg(1'b0, 1'b1, 8'h10);
    wait_n(1);
    write_cfg(1'b0, 1'b0, 8'h10);
    wait_n(1);
    check("R3 leave direct", 8'hFF, 1'b0);
  endtask

  task automatic t_invert();
    write_cfg(1'b1, 1'b1, 8'h24);
    wait_n(1);
    check("R8 inverted direct", 8'h24, 1'b1);
    write_cfg(1'b1, 1'b0, 8'h24);
    wait_n(1);
    check("R8 inverted idle", 8'h00, 1'b0);
    xfer_active = 1'b1;
    txq_empty   = 1'b0;
    wait_n(2);
    check("R8 inverted hw active", 8'h24, 1'b1);
    back_to_idle();
    check("R8 inverted released", 8'h00, 1'b0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec       = 0;
    n_bad       = 0;
    done        = 1'b0;
    rst_n       = 1'b0;
    cfg_we      = 1'b0;
    cfg_wdata   = '0;
    xfer_active = 1'b0;
    txq_empty   = 1'b1;
    hold_sel    = 1'b0;
    sck_tick    = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_hw_idle();
    t_hw_start_gap_tail();
    t_hold();
    t_direct();
    t_invert();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule